// File: doc/BRIEF.md
# Vector element step sequencer

This block keeps the four loop counters that walk a vector operation through its elements: a source element index, a destination element index, and a sub-element index for each side. A vector of VL elements, each a group of one to four sub-elements, is visited one position per advance. Each of these counters can run in two orders. In the plain order the sub-element index is the inner loop. When the matching inversion bit is set, the element index is the inner loop. The source side and the destination side each have their own inversion bit.

Advances come from two places. The issue logic can raise a plain advance request, which takes effect only in horizontal mode. An explicit step command always takes effect. One encoding of the step command immediate does not advance. It loads the two inversion bits instead and reports them back. Every other encoding advances and reports an element index in a 64-bit result. When the last position has been visited, all counters return to zero and a one-cycle end-of-loop pulse is raised.

Top module: `vstep_seq`

## Requirements
- R1: After a synchronous active-low reset, all four counters, both inversion bits, `rt` and `loop_end` are 0.
- R2: With an inversion bit at 0, that side's sub-element counter is the inner loop. It counts from 0 up to the `subvl` code (code n means groups of n+1), then wraps to 0 and adds one to the element counter. A sub-element counter never exceeds the `subvl` code in force when it last advanced.
- R3: With `pack`=1, the source element counter is the inner loop. It counts 0..VL-1, then wraps to 0 and adds one to the source sub-element counter.
- R4: With `unpack`=1, the destination counters follow the inverted order of R3. This does not depend on the source order.
- R5: An advance taken when both counters of a side are at their last value (element VL-1 and sub-element equal to the `subvl` code) clears all four counters to 0. It also drives `loop_end` high for the next cycle only.
- R6: With `vl`=0, any advance leaves the counters unchanged and drives `loop_end` high for the next cycle.
- R7: While `vfirst`=1, `adv_req` is ignored and the counters hold their values.
- R8: `cmd_valid` with a non-mode-set immediate advances once, whatever the value of `vfirst`. If `adv_req` is high in the same cycle, the counters still advance only once.
- R9: `cmd_valid` with `cmd_imm[3:2]`=2'b11 loads `pack` from `cmd_imm[1]` and `unpack` from `cmd_imm[0]`. It leaves the counters unchanged. It sets `rt` to the new {pack, unpack} in bits 1:0, with all other bits 0.
- R10: `cmd_valid` with any other immediate sets `rt` to the source element counter's value after that advance, zero-extended. If `cmd_vf`=1, it uses the destination element counter instead. `rt` holds its value in cycles without `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_req | input | 1 | Advance request from issue; takes effect only in horizontal mode |
| vfirst | input | 1 | Vertical-first mode: 1 blocks `adv_req` |
| cmd_valid | input | 1 | Explicit step command this cycle |
| cmd_imm | input | 7 | Step command immediate |
| cmd_vf | input | 1 | Step command status select: 0 source index, 1 destination index |
| vl | input | 7 | Vector length in elements |
| subvl | input | 2 | Sub-vector group code, 0..3 for 1..4 |
| src_step | output | 7 | Source element counter |
| dst_step | output | 7 | Destination element counter |
| src_sub | output | 2 | Source sub-element counter |
| dst_sub | output | 2 | Destination sub-element counter |
| pack | output | 1 | Source order inversion |
| unpack | output | 1 | Destination order inversion |
| rt | output | 64 | Step command result |
| loop_end | output | 1 | One-cycle end-of-loop pulse |

## Verification
Every result of this block is registered. The counters, the inversion bits, `rt` and `loop_end` all take their new values on the one rising edge that follows the cycle in which a request or command was presented. The bench sets the inputs just after a falling edge. It compares all outputs at the next falling edge, so exactly one rising edge separates each stimulus from its check. The reference model keeps a flat position count and turns it into the expected indices by division and remainder. This ties each expected value to the single edge the stimulus was applied on.

// File: rtl/vsq_pkg.sv
// Package: shared operation encoding for the vector step sequencer.
// Assumes: one operation per cycle, chosen by the command decoder.
package vsq_pkg;
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_ADVANCE = 2'd1,
        OP_MODESET = 2'd2
    } op_e;
endpackage

// File: rtl/vsq_decode.sv
// Module: vsq_decode
// Chooses this cycle's operation from the advance request and the step
// command. It also extracts the two inversion bits that a mode-set command
// carries. Assumes: an explicit command always outranks a plain request.
module vsq_decode
    import vsq_pkg::*;
#(
    parameter int IMM_W = 7
) (
    input  logic             adv_req,
    input  logic             vfirst,
    input  logic             cmd_valid,
    input  logic [IMM_W-1:0] cmd_imm,
    output op_e              op,
    output logic             is_modeset,
    output logic             imm_pack,
    output logic             imm_unpack
);
    localparam int SEL_HI = IMM_W - 4;
    localparam int SEL_LO = IMM_W - 5;
    localparam int PK_BIT = IMM_W - 6;
    localparam int UP_BIT = IMM_W - 7;

    // Purpose: detect the mode-set immediate and pick its payload bits.
    always_comb begin
        is_modeset = cmd_valid && (cmd_imm[SEL_HI:SEL_LO] == 2'b11);
        imm_pack   = cmd_imm[PK_BIT];
        imm_unpack = cmd_imm[UP_BIT];
    end

    // Purpose: priority select of the operation.
    always_comb begin
        if (cmd_valid) begin
            op = (cmd_imm[SEL_HI:SEL_LO] == 2'b11) ? OP_MODESET : OP_ADVANCE;
        end else if (adv_req && !vfirst) begin
            op = OP_ADVANCE;
        end else begin
            op = OP_IDLE;
        end
    end
endmodule

// File: rtl/vsq_lane.sv
// Module: vsq_lane
// Next-state logic for one side (source or destination) of the element walk.
// With invert low the sub-element index is the inner loop; with invert high
// the element index is. Assumes the caller handles vl == 0 on its own; "last"
// uses >= so that an index left out of range by a change of vl still wraps.
module vsq_lane #(
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2
) (
    input  logic [STEP_W-1:0] step,
    input  logic [SUB_W-1:0]  sub,
    input  logic              invert,
    input  logic [STEP_W-1:0] vl,
    input  logic [SUB_W-1:0]  subvl,
    output logic [STEP_W-1:0] nxt_step,
    output logic [SUB_W-1:0]  nxt_sub,
    output logic              last
);
    logic step_last;
    logic sub_last;

    // Purpose: find whether each index has reached its final value.
    always_comb begin
        step_last = (vl == '0) || (step >= (vl - STEP_W'(1)));
        sub_last  = (sub >= subvl);
        last      = step_last && sub_last;
    end

    // Purpose: compute the following position in the chosen loop order.
    always_comb begin
        nxt_step = step;
        nxt_sub  = sub;
        if (last) begin
            nxt_step = '0;
            nxt_sub  = '0;
        end else if (!invert) begin
            if (sub_last) begin
                nxt_sub  = '0;
                nxt_step = step + STEP_W'(1);
            end else begin
                nxt_sub  = sub + SUB_W'(1);
            end
        end else begin
            if (step_last) begin
                nxt_step = '0;
                nxt_sub  = sub + SUB_W'(1);
            end else begin
                nxt_step = step + STEP_W'(1);
            end
        end
    end
endmodule

// File: rtl/vsq_status.sv
// Module: vsq_status
// Forms the 64-bit command result. A mode-set returns the new inversion bits.
// An advance returns the post-advance source or destination element index.
// Assumes the caller only captures the result when a command is present.
module vsq_status
    import vsq_pkg::*;
#(
    parameter int STEP_W = 7,
    parameter int XLEN   = 64
) (
    input  op_e               op,
    input  logic              cmd_vf,
    input  logic [STEP_W-1:0] src_after,
    input  logic [STEP_W-1:0] dst_after,
    input  logic              pack_new,
    input  logic              unpack_new,
    output logic [XLEN-1:0]   result
);
    // Purpose: select and zero-extend the reported value.
    always_comb begin
        result = '0;
        if (op == OP_MODESET) begin
            result[1:0] = {pack_new, unpack_new};
        end else begin
            result[STEP_W-1:0] = cmd_vf ? dst_after : src_after;
        end
    end
endmodule

// File: rtl/vstep_seq.sv
// Module: vstep_seq (top)
// Holds the source/destination element and sub-element counters and the two
// loop-order inversion bits, and advances them on requests or step commands.
// Assumes both sides start together at zero, so that they reach their last
// position on the same advance; either side reaching it ends the loop.
module vstep_seq
    import vsq_pkg::*;
#(
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2,
    parameter int IMM_W  = 7,
    parameter int XLEN   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_req,
    input  logic              vfirst,
    input  logic              cmd_valid,
    input  logic [IMM_W-1:0]  cmd_imm,
    input  logic              cmd_vf,
    input  logic [STEP_W-1:0] vl,
    input  logic [SUB_W-1:0]  subvl,
    output logic [STEP_W-1:0] src_step,
    output logic [STEP_W-1:0] dst_step,
    output logic [SUB_W-1:0]  src_sub,
    output logic [SUB_W-1:0]  dst_sub,
    output logic              pack,
    output logic              unpack,
    output logic [XLEN-1:0]   rt,
    output logic              loop_end
);
    localparam int SEL_HI = IMM_W - 4;
    localparam int SEL_LO = IMM_W - 5;

    op_e               op;
    logic              is_modeset;
    logic              imm_pack;
    logic              imm_unpack;
    logic [STEP_W-1:0] s_nstep;
    logic [STEP_W-1:0] d_nstep;
    logic [SUB_W-1:0]  s_nsub;
    logic [SUB_W-1:0]  d_nsub;
    logic              s_last;
    logic              d_last;
    logic              vl_zero;
    logic              wrap;
    logic [STEP_W-1:0] src_after;
    logic [STEP_W-1:0] dst_after;
    logic [SUB_W-1:0]  ssub_after;
    logic [SUB_W-1:0]  dsub_after;
    logic              pack_new;
    logic              unpack_new;
    logic [XLEN-1:0]   stat;

    vsq_decode #(.IMM_W(IMM_W)) u_dec (
        .adv_req    (adv_req),
        .vfirst     (vfirst),
        .cmd_valid  (cmd_valid),
        .cmd_imm    (cmd_imm),
        .op         (op),
        .is_modeset (is_modeset),
        .imm_pack   (imm_pack),
        .imm_unpack (imm_unpack)
    );

    vsq_lane #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_src (
        .step     (src_step),
        .sub      (src_sub),
        .invert   (pack),
        .vl       (vl),
        .subvl    (subvl),
        .nxt_step (s_nstep),
        .nxt_sub  (s_nsub),
        .last     (s_last)
    );

    vsq_lane #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_dst (
        .step     (dst_step),
        .sub      (dst_sub),
        .invert   (unpack),
        .vl       (vl),
        .subvl    (subvl),
        .nxt_step (d_nstep),
        .nxt_sub  (d_nsub),
        .last     (d_last)
    );

    // Purpose: combine both lanes into the position after an advance.
    always_comb begin
        vl_zero = (vl == '0);
        wrap    = s_last || d_last;
        if (vl_zero) begin
            src_after  = src_step;
            dst_after  = dst_step;
            ssub_after = src_sub;
            dsub_after = dst_sub;
        end else if (wrap) begin
            src_after  = '0;
            dst_after  = '0;
            ssub_after = '0;
            dsub_after = '0;
        end else begin
            src_after  = s_nstep;
            dst_after  = d_nstep;
            ssub_after = s_nsub;
            dsub_after = d_nsub;
        end
        pack_new   = is_modeset ? imm_pack : pack;
        unpack_new = is_modeset ? imm_unpack : unpack;
    end

    vsq_status #(.STEP_W(STEP_W), .XLEN(XLEN)) u_stat (
        .op         (op),
        .cmd_vf     (cmd_vf),
        .src_after  (src_after),
        .dst_after  (dst_after),
        .pack_new   (pack_new),
        .unpack_new (unpack_new),
        .result     (stat)
    );

    // Purpose: state registers for counters, mode bits, result and pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_step <= '0;
            dst_step <= '0;
            src_sub  <= '0;
            dst_sub  <= '0;
            pack     <= 1'b0;
            unpack   <= 1'b0;
            rt       <= '0;
            loop_end <= 1'b0;
        end else begin
            loop_end <= 1'b0;
            case (op)
                OP_ADVANCE: begin
                    src_step <= src_after;
                    dst_step <= dst_after;
                    src_sub  <= ssub_after;
                    dst_sub  <= dsub_after;
                    loop_end <= vl_zero || wrap;
                end
                OP_MODESET: begin
                    pack   <= pack_new;
                    unpack <= unpack_new;
                end
                default: begin
                end
            endcase
            if (cmd_valid) begin
                rt <= stat;
            end
        end
    end

    AST_SUB_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_imm[SEL_HI:SEL_LO] != 2'b11 && vl != '0)
        |=> (src_sub <= $past(subvl)) && (dst_sub <= $past(subvl))); // R2

    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_end && $past(vl) != '0)
        |-> (src_step == '0 && dst_step == '0 && src_sub == '0 && dst_sub == '0)); // R5

    AST_VL_ZERO_END: assert property (@(posedge clk) disable iff (!rst_n)
        (vl == '0 && cmd_valid && cmd_imm[SEL_HI:SEL_LO] != 2'b11)
        |=> loop_end && $stable({src_step, dst_step, src_sub, dst_sub})); // R6

    AST_VFIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vfirst && !cmd_valid)
        |=> $stable({src_step, dst_step, src_sub, dst_sub}) && !loop_end); // R7

    AST_MODESET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_imm[SEL_HI:SEL_LO] == 2'b11)
        |=> $stable({src_step, dst_step, src_sub, dst_sub}) && !loop_end
            && (rt[1:0] == {pack, unpack})); // R9

    AST_RT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(rt)); // R10
endmodule

// File: tb/sim_vstep_seq.sv
module sim_vstep_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_req = 1'b0;
    logic        vfirst = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [6:0]  cmd_imm = '0;
    logic        cmd_vf = 1'b0;
    logic [6:0]  vl = '0;
    logic [1:0]  subvl = '0;
    logic [6:0]  src_step, dst_step;
    logic [1:0]  src_sub, dst_sub;
    logic        pack, unpack, loop_end;
    logic [63:0] rt;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    int          m_idx = 0;
    bit          m_pack = 0, m_unpack = 0, m_eol = 0;
    logic [63:0] m_rt = '0;
    string       ctr_tag = "R1";

    always #4 clk = ~clk;

    vstep_seq u0 (
        .clk(clk), .rst_n(rst_n), .adv_req(adv_req), .vfirst(vfirst),
        .cmd_valid(cmd_valid), .cmd_imm(cmd_imm), .cmd_vf(cmd_vf),
        .vl(vl), .subvl(subvl), .src_step(src_step), .dst_step(dst_step),
        .src_sub(src_sub), .dst_sub(dst_sub), .pack(pack), .unpack(unpack),
        .rt(rt), .loop_end(loop_end)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int e_step(input bit inv, input int idx, input int v, input int s);
        if (v == 0) return 0;
        return inv ? (idx % v) : (idx / (s + 1));
    endfunction

    function automatic int e_sub(input bit inv, input int idx, input int v, input int s);
        if (v == 0) return 0;
        return inv ? (idx / v) : (idx % (s + 1));
    endfunction

    task automatic compare();
        string st, dt, et, rtag;
        st = (ctr_tag != "") ? ctr_tag : (m_pack ? "R3" : "R2");
        dt = (ctr_tag != "") ? ctr_tag : (m_unpack ? "R4" : "R2");
        et = (vl == 0) ? "R6" : "R5";
        rtag = "R10";
        chk(src_step == 7'(e_step(m_pack, m_idx, vl, subvl)), st, src_step, e_step(m_pack, m_idx, vl, subvl));
        chk(src_sub == 2'(e_sub(m_pack, m_idx, vl, subvl)), st, src_sub, e_sub(m_pack, m_idx, vl, subvl));
        chk(dst_step == 7'(e_step(m_unpack, m_idx, vl, subvl)), dt, dst_step, e_step(m_unpack, m_idx, vl, subvl));
        chk(dst_sub == 2'(e_sub(m_unpack, m_idx, vl, subvl)), dt, dst_sub, e_sub(m_unpack, m_idx, vl, subvl));
        chk(loop_end == m_eol, et, loop_end, m_eol);
        chk({pack, unpack} == {m_pack, m_unpack}, "R9", {pack, unpack}, {m_pack, m_unpack});
        chk(rt == m_rt, rtag, rt, m_rt);
    endtask

    // apply one cycle of stimulus, advance the model, check at the next falling edge
    task automatic cyc(input bit adv, input bit vf, input bit cmd, input logic [6:0] imm,
                       input bit cvf, input logic [6:0] v, input logic [1:0] sv);
        bit advance;
        adv_req = adv; vfirst = vf; cmd_valid = cmd; cmd_imm = imm; cmd_vf = cvf;
        vl = v; subvl = sv;
        m_eol = 0;
        ctr_tag = "";
        if (adv && vf && !cmd) ctr_tag = "R7";
        if (cmd && adv && imm[3:2] != 2'b11) ctr_tag = "R8";
        if (cmd && imm[3:2] == 2'b11) begin
            m_pack = imm[1]; m_unpack = imm[0];
            m_rt = {62'd0, imm[1], imm[0]};
            ctr_tag = "R9";
        end else begin
            advance = cmd || (adv && !vf);
            if (advance) begin
                if (v == 0) m_eol = 1;
                else begin
                    m_idx++;
                    if (m_idx >= int'(v) * (int'(sv) + 1)) begin
                        m_idx = 0; m_eol = 1;
                    end
                end
                if (cmd) m_rt = 64'(cvf ? e_step(m_unpack, m_idx, v, sv)
                                        : e_step(m_pack, m_idx, v, sv));
            end
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [6:0] cv;
        logic [1:0] cs;
        seed = $urandom(1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ctr_tag = "R1";
        compare();                                   // R1 reset state
        // R2 plain order, vl=3, groups of 2, full loop with end pulse (R5)
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 7'd0, 0, 7'd3, 2'd1);
        // R9 mode set: pack=1, unpack=0, rt=2'b10
        cyc(0, 0, 1, 7'b0001110, 0, 7'd3, 2'd1);
        // R3 inverted source, R10 rt reports src / dst index
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 7'd0, i[0], 7'd3, 2'd1);
        // R4 inverted destination only
        cyc(0, 0, 1, 7'b0001101, 0, 7'd4, 2'd2);
        for (int i = 0; i < 12; i++) cyc(1, 0, 0, 7'd0, 0, 7'd4, 2'd2);
        // R7 vertical-first ignores adv_req; R8 explicit command still steps
        cyc(1, 1, 0, 7'd0, 0, 7'd4, 2'd2);
        cyc(1, 1, 0, 7'd0, 0, 7'd4, 2'd2);
        cyc(0, 1, 1, 7'd5, 0, 7'd4, 2'd2);
        cyc(1, 1, 1, 7'd1, 1, 7'd4, 2'd2);
        cyc(1, 0, 1, 7'd0, 0, 7'd4, 2'd2);
        for (int i = 0; i < 9; i++) cyc(0, 1, 1, 7'd0, 0, 7'd4, 2'd2);
        // R6 vl = 0
        cyc(1, 0, 0, 7'd0, 0, 7'd0, 2'd3);
        cyc(0, 0, 1, 7'd0, 0, 7'd0, 2'd0);
        // R5 single element loop
        cyc(1, 0, 0, 7'd0, 0, 7'd1, 2'd0);
        // random phase: shape and mode change only at loop start
        cv = 7'd5; cs = 2'd1;
        for (int i = 0; i < 4000; i++) begin
            bit a, f, c, ms;
            logic [6:0] im;
            if (m_idx == 0 && ($urandom % 4) == 0) begin
                cv = 7'($urandom % 10);
                if (($urandom % 16) == 0) cv = 7'd127;
                cs = 2'($urandom % 4);
            end
            a = ($urandom % 2) == 1;
            f = ($urandom % 3) == 0;
            c = ($urandom % 3) == 0;
            ms = (m_idx == 0) && (($urandom % 5) == 0);
            im = 7'($urandom);
            if (c) im[3:2] = ms ? 2'b11 : 2'(($urandom % 3));
            cyc(a, f, c, im, ($urandom % 2) == 1, cv, cs);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule